// File: doc/BRIEF.md
# Pseudo-Associative Read Cache Controller

This block serves single-word read requests from a small cache whose storage is organised as one direct-mapped array cut into two halves. Each address has a home slot selected by its index bits, and a partner slot in the opposite half, reached by flipping the top index bit. The home slot is compared on the first cycle after a request is accepted. If it misses, the partner slot is compared one cycle later. If both compares fail, the controller raises a request toward lower memory and waits for the fill.

A requester holds `req_valid` and `req_addr` steady until `rsp_ready` pulses for one cycle with the read word on `rsp_rdata`. It then drops the request for at least one cycle before issuing the next one. Response latency depends on where the line was found: one cycle, two cycles, or the miss latency. Lines found in the partner slot are exchanged with the home slot. Filled lines take the home slot and push the previous home line into the partner slot.

Top module: `pac_cache`

## Requirements
- R1: After reset every slot is invalid and `rsp_ready` and `mem_req` are low, so the first access to any address is a full miss.
- R2: A request accepted on an edge where `rsp_ready` is low and whose line sits in its home slot returns `rsp_ready` high with the correct word one cycle later.
- R3: A request whose line sits only in the partner slot (home index with its most significant bit inverted) returns `rsp_ready` high with the correct word two cycles later.
- R4: When both slots miss, `mem_req` rises two cycles after acceptance, stays high until a fill is delivered, and `mem_addr` carries the requested address for the whole time.
- R5: On the edge that samples `mem_fill_valid` while `mem_req` is high, the controller raises `rsp_ready` one cycle later with the fill word on `rsp_rdata`.
- R6: After a partner-slot hit the two slots are exchanged: the same address next hits in one cycle, and the line that was in the home slot is then found in two cycles.
- R7: After a fill the new line occupies the home slot, the former home line moves to the partner slot, and the former partner line is discarded and misses on its next access.
- R8: Stored tags include the most significant index bit, so two addresses that differ only in that bit never match each other's line, while a line found in the other half is still recognised.
- R9: `rsp_ready` is high for exactly one cycle per request and is never high while `mem_req` is high.
- R10: `mem_fill_valid` is ignored when no miss is outstanding: it raises no response and alters no stored line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present; held until `rsp_ready` |
| req_addr | input | ADDR_W | Word address of the read |
| rsp_ready | output | 1 | One-cycle pulse: read completed |
| rsp_rdata | output | DATA_W | Read word, valid with `rsp_ready` |
| mem_req | output | 1 | Line fetch toward lower memory outstanding |
| mem_addr | output | ADDR_W | Address of the outstanding fetch |
| mem_fill_valid | input | 1 | Fill word delivered this cycle |
| mem_fill_data | input | DATA_W | Fill word |

## Verification
With one cycle counted per clock after the edge that accepts a request, a home hit must answer in cycle 1, a partner hit in cycle 2, and a miss must show `mem_req` in cycle 2 and answer in the cycle after the fill is sampled. The bench samples every output on the falling edge and counts falling edges from the one at which it drives the request, so the observed count is compared directly with 1, 2 or 3 plus the fill delay it chose. A reference slot map in the bench, updated by the exchange and fill rules, predicts which of the three latencies each access must see across a long pseudo-random address stream with varied fill delays.

// File: rtl/pac_pkg.sv
// Shared types for the pseudo-associative cache controller.
// Assumes nothing beyond the 1800-2017 language.
package pac_pkg;

    // Controller sequencing: home compare, partner compare, miss wait.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ALT  = 2'd1,
        ST_MISS = 2'd2
    } pac_state_t;

endpackage

// File: rtl/pac_store.sv
// Slot storage: DEPTH lines of {valid, tag, data}, two read ports and two
// write ports. Assumes the two write ports never target the same slot in
// one cycle (the controller always writes a home/partner pair).
module pac_store #(
    parameter int IDX_W  = 3,
    parameter int LINE_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic [IDX_W-1:0]  rd1_idx,
    output logic [LINE_W-1:0] rd0_line,
    output logic [LINE_W-1:0] rd1_line,
    input  logic              wr0_en,
    input  logic [IDX_W-1:0]  wr0_idx,
    input  logic [LINE_W-1:0] wr0_line,
    input  logic              wr1_en,
    input  logic [IDX_W-1:0]  wr1_idx,
    input  logic [LINE_W-1:0] wr1_line
);
    localparam int DEPTH = 1 << IDX_W;

    logic [LINE_W-1:0] slot_q [DEPTH];

    // Clear all slots on reset, otherwise apply the two write ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            if (wr0_en) slot_q[wr0_idx] <= wr0_line;
            if (wr1_en) slot_q[wr1_idx] <= wr1_line;
        end
    end

    // Asynchronous read of both probe slots.
    always_comb begin
        rd0_line = slot_q[rd0_idx];
        rd1_line = slot_q[rd1_idx];
    end
endmodule

// File: rtl/pac_match.sv
// Tag comparator for one slot: reports a hit when the slot is valid and its
// stored tag equals the probe tag, and forwards the slot data.
// Assumes line layout {valid, tag, data} with valid in the top bit.
module pac_match #(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic [TAG_W+DATA_W:0] line,
    input  logic [TAG_W-1:0]      probe_tag,
    output logic                  hit,
    output logic [DATA_W-1:0]     data
);
    // Compare the stored tag and qualify with the valid bit.
    always_comb begin
        hit  = line[TAG_W+DATA_W] && (line[TAG_W+DATA_W-1:DATA_W] == probe_tag);
        data = line[DATA_W-1:0];
    end
endmodule

// File: rtl/pac_ctrl.sv
// Probe sequencer. Accepts a request when idle and no response is showing,
// compares the home slot that cycle, the partner slot the next, then waits
// for a fill. Exchanges the pair on a partner hit; on a fill places the new
// line home and moves the old home line to the partner slot.
// Assumes the requester holds req_addr stable until rsp_ready.
module pac_ctrl
    import pac_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16,
    parameter int TAG_W  = ADDR_W - IDX_W + 1,
    parameter int LINE_W = 1 + TAG_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [IDX_W-1:0]  home_idx,
    output logic [IDX_W-1:0]  part_idx,
    output logic [TAG_W-1:0]  probe_tag,
    input  logic              home_hit,
    input  logic              part_hit,
    input  logic [DATA_W-1:0] home_data,
    input  logic [DATA_W-1:0] part_data,
    input  logic [LINE_W-1:0] home_line,
    input  logic [LINE_W-1:0] part_line,
    output logic              wr0_en,
    output logic [IDX_W-1:0]  wr0_idx,
    output logic [LINE_W-1:0] wr0_line,
    output logic              wr1_en,
    output logic [IDX_W-1:0]  wr1_idx,
    output logic [LINE_W-1:0] wr1_line,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_fill_valid,
    input  logic [DATA_W-1:0] mem_fill_data
);
    localparam logic [IDX_W-1:0] HALF_BIT = {1'b1, {(IDX_W-1){1'b0}}};

    pac_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              accept;
    logic              ready_d;
    logic [DATA_W-1:0] rdata_d;
    logic              ready_q;
    logic [DATA_W-1:0] rdata_q;

    // Probe address: live request while idle, latched address afterwards.
    always_comb begin
        cur_addr  = (state_q == ST_IDLE) ? req_addr : addr_q;
        home_idx  = cur_addr[IDX_W-1:0];
        part_idx  = cur_addr[IDX_W-1:0] ^ HALF_BIT;
        probe_tag = cur_addr[ADDR_W-1:IDX_W-1];
        accept    = (state_q == ST_IDLE) && req_valid && !ready_q;
    end

    // Next state, response and slot updates for each probe step.
    always_comb begin
        state_d  = state_q;
        ready_d  = 1'b0;
        rdata_d  = rdata_q;
        wr0_en   = 1'b0;
        wr0_idx  = home_idx;
        wr0_line = part_line;
        wr1_en   = 1'b0;
        wr1_idx  = part_idx;
        wr1_line = home_line;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (home_hit) begin
                        ready_d = 1'b1;
                        rdata_d = home_data;
                    end else begin
                        state_d = ST_ALT;
                    end
                end
            end
            ST_ALT: begin
                if (part_hit) begin
                    ready_d = 1'b1;
                    rdata_d = part_data;
                    wr0_en  = 1'b1;
                    wr1_en  = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_MISS;
                end
            end
            ST_MISS: begin
                if (mem_fill_valid) begin
                    ready_d  = 1'b1;
                    rdata_d  = mem_fill_data;
                    wr0_en   = 1'b1;
                    wr0_line = {1'b1, probe_tag, mem_fill_data};
                    wr1_en   = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, latched address and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            ready_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            ready_q <= ready_d;
            rdata_q <= rdata_d;
            if (accept) addr_q <= req_addr;
        end
    end

    // Drive the response and lower-memory request from registers.
    always_comb begin
        rsp_ready = ready_q;
        rsp_rdata = rdata_q;
        mem_req   = (state_q == ST_MISS);
        mem_addr  = addr_q;
    end
endmodule

// File: rtl/pac_cache.sv
// Top of the pseudo-associative read cache: storage, two tag comparators
// (home and partner) and the probe sequencer.
// Assumes one outstanding request and a held request until rsp_ready.
module pac_cache #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_fill_valid,
    input  logic [DATA_W-1:0] mem_fill_data
);
    localparam int TAG_W  = ADDR_W - IDX_W + 1;
    localparam int LINE_W = 1 + TAG_W + DATA_W;
    localparam int NPROBE = 2;

    logic [IDX_W-1:0]  home_idx, part_idx;
    logic [TAG_W-1:0]  probe_tag;
    logic [LINE_W-1:0] probe_line [NPROBE];
    logic              probe_hit  [NPROBE];
    logic [DATA_W-1:0] probe_data [NPROBE];
    logic              wr0_en, wr1_en;
    logic [IDX_W-1:0]  wr0_idx, wr1_idx;
    logic [LINE_W-1:0] wr0_line, wr1_line;
    logic [LINE_W-1:0] rd0_line, rd1_line;

    pac_store #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd0_idx(home_idx), .rd1_idx(part_idx),
        .rd0_line(rd0_line), .rd1_line(rd1_line),
        .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_line(wr0_line),
        .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_line(wr1_line)
    );

    // Route the two read ports to the probe comparators.
    always_comb begin
        probe_line[0] = rd0_line;
        probe_line[1] = rd1_line;
    end

    for (genvar p = 0; p < NPROBE; p++) begin : g_probe
        pac_match #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_match (
            .line(probe_line[p]), .probe_tag(probe_tag),
            .hit(probe_hit[p]), .data(probe_data[p])
        );
    end

    pac_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr),
        .home_idx(home_idx), .part_idx(part_idx), .probe_tag(probe_tag),
        .home_hit(probe_hit[0]), .part_hit(probe_hit[1]),
        .home_data(probe_data[0]), .part_data(probe_data[1]),
        .home_line(probe_line[0]), .part_line(probe_line[1]),
        .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_line(wr0_line),
        .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_line(wr1_line),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data)
    );
endmodule

// File: rtl/pac_checker.sv
// Protocol checks on the ports of pac_cache, attached with bind.
module pac_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_fill_valid
);
    // R1: reset leaves no response and no fetch.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!rsp_ready && !mem_req));

    // R2: a response always answers a request that was being held.
    a_r2_ready_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> $past(req_valid));

    // R4: an outstanding fetch stays up until a fill arrives.
    a_r4_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_fill_valid) |=> mem_req);

    // R4: the fetch address does not move while the fetch is outstanding.
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));

    // R5: a sampled fill produces a response on the next cycle.
    a_r5_fill_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_fill_valid) |=> (rsp_ready && !mem_req));

    // R9: the response is a single-cycle pulse.
    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

    // R9: response and fetch are never up together.
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ready && mem_req));

    // R10: a stray fill while idle raises no response.
    a_r10_stray_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && !req_valid && !rsp_ready) |=> !rsp_ready);
endmodule

bind pac_cache pac_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pac_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_fill_valid(mem_fill_valid)
);

// File: tb/test_pac_cache.sv
// Bench for pac_cache: directed placement cases, then a long pseudo-random
// sweep over 32 addresses predicted by a reference slot map.
module test_pac_cache;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = 3;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_ready;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_fill_valid = 1'b0;
    logic [DATA_W-1:0] mem_fill_data = '0;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    // Reference slot map: valid and full tag (address bits 7..2).
    bit       mv [8];
    bit [5:0] mt [8];

    pac_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_pac_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_fill_valid(mem_fill_valid),
        .mem_fill_data(mem_fill_data)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [7:0] a);
        return {a, a ^ 8'h5A};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One read. exp_kind 1=home hit, 2=partner hit, 3=miss, 0=take model.
    task automatic do_access(input logic [7:0] a, input int lat, input int exp_kind,
                             input string req);
        int idx, alt, kind, n, memcnt;
        bit [5:0] ft;
        idx = int'(a[2:0]);
        alt = idx ^ 4;
        ft  = a[7:2];
        if (mv[idx] && mt[idx] == ft)      kind = 1;
        else if (mv[alt] && mt[alt] == ft) kind = 2;
        else                               kind = 3;
        if (exp_kind != 0) chk(kind == exp_kind, {req, " model"}, kind, exp_kind);
        req_valid = 1'b1;
        req_addr  = a;
        n = 0;
        memcnt = 0;
        while (n < 40) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (mem_req) begin
                if (memcnt == 0) begin
                    chk(n == 2, "R4 fetch cycle", n, 2);
                    chk(mem_addr == a, "R4 fetch address", mem_addr, a);
                end
                if (memcnt == lat) begin
                    mem_fill_valid = 1'b1;
                    mem_fill_data  = mem_word(a);
                end
                memcnt++;
            end
            if (rsp_ready) break;
        end
        mem_fill_valid = 1'b0;
        if (kind == 1) chk(n == 1, {req, " R2 latency"}, n, 1);
        else if (kind == 2) chk(n == 2, {req, " R3 latency"}, n, 2);
        else chk(n == 3 + lat, {req, " R5 latency"}, n, 3 + lat);
        chk(rsp_rdata == mem_word(a), {req, " data"}, rsp_rdata, mem_word(a));
        chk(!mem_req, "R9 no fetch with response", mem_req, 0);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!rsp_ready, "R9 single pulse", rsp_ready, 0);
        if (kind == 2) begin
            mv[alt] = mv[idx]; mt[alt] = mt[idx];
            mv[idx] = 1'b1;    mt[idx] = ft;
        end else if (kind == 3) begin
            mv[alt] = mv[idx]; mt[alt] = mt[idx];
            mv[idx] = 1'b1;    mt[idx] = ft;
        end
    endtask

    // Main sequence.
    initial begin
        for (int i = 0; i < 8; i++) begin mv[i] = 1'b0; mt[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_ready, "R1 ready after reset", rsp_ready, 0);
        chk(!mem_req, "R1 fetch after reset", mem_req, 0);

        do_access(8'h00, 2, 3, "R1 first access");
        do_access(8'h00, 0, 1, "R2 home");
        do_access(8'h08, 0, 3, "R7 fill");
        do_access(8'h00, 0, 2, "R7 old home to partner");
        do_access(8'h00, 0, 1, "R6 swapped home");
        do_access(8'h08, 0, 2, "R6 swapped out");
        do_access(8'h04, 1, 3, "R8 other half tag");
        do_access(8'h08, 3, 3, "R7 displaced");
        do_access(8'h00, 0, 2, "R8 found in other half");

        // R10: stray fills while idle.
        mem_fill_valid = 1'b1;
        mem_fill_data  = 16'hDEAD;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!rsp_ready, "R10 no response", rsp_ready, 0);
            chk(!mem_req, "R10 no fetch", mem_req, 0);
        end
        mem_fill_valid = 1'b0;
        @(negedge clk);
        do_access(8'h00, 0, 1, "R10 line intact");
        do_access(8'h08, 0, 2, "R10 partner intact");

        // Sweep: 32 addresses, varied fill delay, model-predicted outcome.
        begin
            logic [7:0] s;
            s = 8'h1D;
            for (int i = 0; i < 400; i++) begin
                s = s * 8'd5 + 8'd7;
                do_access({3'b000, s[6:2]}, i % 4, 0, "sweep");
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule